// File: doc/BRIEF.md
# Audio Clock Supervisor with Ratio Detection

This block watches the three clocks that feed the serial input of an audio DAC: the master clock, the bit clock and the frame clock. It runs entirely on a free-running reference clock and sees the audio clocks only through two-flop synchronizers. It decides when the datapath may run. After reset the datapath is held in power-down with its output high-impedance until all three clocks have been seen toggling. Later, if the master clock stops for longer than a programmable timeout while the chip is enabled, the datapath is powered down again. It restarts as soon as master-clock edges return, and the ratio and speed results are kept.

Two setting modes are supported. In manual mode the sampling-speed class comes from a 3-bit field, or is forced to normal speed when the part is strapped for pin control. In auto mode the block measures the frame length in reference cycles to find the speed class. It also counts master-clock edges per frame and matches the count against the legal ratio set. A result is taken only when two consecutive frames agree, and the last good result is held otherwise.

Top module: `aclk_supervisor`

## Requirements
- R1: After reset, dp_pwrdn=1, out_hiz=1, mclk_lost=0, auto_active=0, speed_class=0, ratio_code=0 and ratio_bad=0.
- R2: dp_pwrdn and out_hiz stay 1 after reset until each of the master, bit and frame clocks has given at least 4 synchronized rising edges inside one of its presence windows. After that they drop to 0 while chip_en=1 and the master clock runs.
- R3: With chip_en=1, if no master-clock rising edge is seen for STOP_CYC reference cycles, mclk_lost goes to 1 and dp_pwrdn and out_hiz go to 1. mclk_lost is never set while chip_en=0.
- R4: When master-clock edges return, mclk_lost clears and dp_pwrdn/out_hiz return to 0 within a few reference cycles. ratio_code and speed_class keep the values they had before the loss.
- R5: auto_sel=0 selects manual mode and auto_sel=1 selects auto mode, shown on auto_active. In the first cycle after chip_en rises, auto_active is 0 whatever the value of auto_sel.
- R6: In manual mode with pin_mode=0, speed_class follows speed_field one cycle later. The encoding is 0 normal, 1 double, 2 quad, 3 octal, 4 hex. Field values 5 to 7 give normal (0).
- R7: In manual mode with pin_mode=1, speed_class is 0 (normal) whatever speed_field holds.
- R8: In auto mode, each frame's master-clock edge count is matched within ±RATIO_TOL against 256, 384, 512, 768 and 1152, giving codes 0, 1, 2, 3 and 4. A code is published, with ratio_bad=0, only after two consecutive frames give the same code and speed class.
- R9: Code 4 (1152) is legal only when the frame is in the normal class and at least FS32_FRAME_MIN reference cycles long. At a shorter normal-speed frame, a 1152 count is invalid.
- R10: A frame whose count matches no legal ratio (including 128 and 192), or that does not complete a two-frame match, sets ratio_bad=1. While ratio_bad=1, ratio_code does not change.
- R11: In auto mode, speed_class is the class of the accepted frame length L in reference cycles: normal if L>=NORM_FRAME_MIN, double if L>=NORM_FRAME_MIN/2, quad if L>=NORM_FRAME_MIN/4, octal if L>=NORM_FRAME_MIN/8, hex otherwise.
- R12: chip_en=0 drives dp_pwrdn and out_hiz to 1 on the next cycle.
- R13: In manual mode, ratio_bad reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running reference clock |
| rst | input | 1 | Synchronous active-high reset |
| mclk | input | 1 | Master clock, asynchronous |
| bclk | input | 1 | Bit clock (expected at 64 times the frame rate), asynchronous |
| fclk | input | 1 | Frame (word-select) clock, asynchronous |
| chip_en | input | 1 | Chip enable; 0 forces power-down |
| auto_sel | input | 1 | 0 manual setting, 1 auto setting |
| pin_mode | input | 1 | 1 pin control (speed forced normal), 0 register control |
| speed_field | input | 3 | Manual speed class selection |
| dp_pwrdn | output | 1 | Datapath power-down request |
| out_hiz | output | 1 | Analog output high-impedance request |
| mclk_lost | output | 1 | Master clock stop detected |
| auto_active | output | 1 | Auto setting mode in effect |
| speed_class | output | 3 | Sampling-speed class in effect |
| ratio_code | output | 3 | Last accepted master-clock ratio code |
| ratio_bad | output | 1 | Current frame gave no accepted ratio |

## Verification
A bad stop-timeout counter shows as mclk_lost rising too early, while the master clock runs slowly, or never rising. Either shows at dp_pwrdn within about STOP_CYC cycles of the clock stopping. A fault in the frame counters or the two-frame match shows as a wrong ratio_code or speed_class, or a ratio_bad that stays up on a steady legal input. These appear within three frames of a clock change, so each auto case is sampled four frames after it is set up. A presence or start latch that is wrong shows as a datapath released while the frame clock is still absent, or never released.

// File: rtl/aclk_pkg.sv
package aclk_pkg;

    typedef enum logic [2:0] {
        SPD_NORMAL = 3'd0,
        SPD_DOUBLE = 3'd1,
        SPD_QUAD   = 3'd2,
        SPD_OCTAL  = 3'd3,
        SPD_HEX    = 3'd4
    } speed_e;

    typedef enum logic [2:0] {
        RT_256  = 3'd0,
        RT_384  = 3'd1,
        RT_512  = 3'd2,
        RT_768  = 3'd3,
        RT_1152 = 3'd4
    } ratio_e;

    localparam int NUM_RATIOS = 5;

    typedef struct packed {
        logic   ok;
        ratio_e code;
    } ratio_res_t;

    function automatic int nominal_ratio(input int idx);
        case (idx)
            0:       return 256;
            1:       return 384;
            2:       return 512;
            3:       return 768;
            default: return 1152;
        endcase
    endfunction

    // Reserved field values fall back to normal speed
    function automatic speed_e field_to_speed(input logic [2:0] f);
        if (f <= 3'd4) return speed_e'(f);
        return SPD_NORMAL;
    endfunction

    function automatic speed_e classify_len(input int len, input int norm_min);
        if (len >= norm_min)     return SPD_NORMAL;
        if (len >= norm_min / 2) return SPD_DOUBLE;
        if (len >= norm_min / 4) return SPD_QUAD;
        if (len >= norm_min / 8) return SPD_OCTAL;
        return SPD_HEX;
    endfunction

    // 1152 is only legal on a long normal-speed frame
    function automatic ratio_res_t match_ratio(input int cnt, input speed_e cls,
                                               input logic long_frame, input int tol);
        ratio_res_t res;
        res.ok   = 1'b0;
        res.code = RT_256;
        for (int i = 0; i < NUM_RATIOS; i++) begin
            int d;
            d = cnt - nominal_ratio(i);
            if (d <= tol && d >= -tol) begin
                if (i != NUM_RATIOS - 1 || (cls == SPD_NORMAL && long_frame)) begin
                    res.ok   = 1'b1;
                    res.code = ratio_e'(i[2:0]);
                end
            end
        end
        return res;
    endfunction

endpackage

// File: rtl/clk_edge_det.sv
module clk_edge_det (
    input  logic clk,
    input  logic rst,
    input  logic async_i,
    output logic rise_o
);
    logic [2:0] pipe_q;

    always_ff @(posedge clk) begin
        if (rst) pipe_q <= '0;
        else     pipe_q <= {pipe_q[1:0], async_i};
    end

    assign rise_o = pipe_q[1] & ~pipe_q[2];
endmodule

// File: rtl/clk_presence.sv
module clk_presence #(
    parameter int WIN       = 200,
    parameter int MIN_EDGES = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic rise_i,
    output logic present_o
);
    localparam int WCW = $clog2(WIN + 1);
    localparam int EW  = $clog2(MIN_EDGES + 1);

    logic [WCW-1:0] win_q;
    logic [EW-1:0]  edges_q;
    logic [EW:0]    edges_nx;

    assign edges_nx = {1'b0, edges_q} + {{EW{1'b0}}, rise_i};

    always_ff @(posedge clk) begin
        if (rst) begin
            win_q     <= '0;
            edges_q   <= '0;
            present_o <= 1'b0;
        end else if (win_q == WCW'(WIN - 1)) begin
            win_q     <= '0;
            edges_q   <= '0;
            present_o <= edges_nx >= (EW+1)'(MIN_EDGES);
        end else begin
            win_q <= win_q + 1'b1;
            if (rise_i && edges_q != EW'(MIN_EDGES)) edges_q <= edges_q + 1'b1;
        end
    end
endmodule

// File: rtl/ratio_meter.sv
module ratio_meter
    import aclk_pkg::*;
#(
    parameter int CNT_W          = 12,
    parameter int LEN_W          = 16,
    parameter int NORM_FRAME_MIN = 3100,
    parameter int FS32_FRAME_MIN = 5400,
    parameter int RATIO_TOL      = 2
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   enable,
    input  logic   mrise,
    input  logic   frise,
    output ratio_e code_o,
    output speed_e spd_o,
    output logic   bad_o
);
    logic [CNT_W-1:0] mcnt_q;
    logic [LEN_W-1:0] flen_q;
    logic             prev_ok_q;
    ratio_e           prev_code_q;
    speed_e           prev_spd_q;
    speed_e           cls;
    ratio_res_t       res;

    always_comb begin
        cls = classify_len(int'(flen_q), NORM_FRAME_MIN);
        res = match_ratio(int'(mcnt_q), cls, int'(flen_q) >= FS32_FRAME_MIN, RATIO_TOL);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mcnt_q      <= '0;
            flen_q      <= '0;
            prev_ok_q   <= 1'b0;
            prev_code_q <= RT_256;
            prev_spd_q  <= SPD_NORMAL;
            code_o      <= RT_256;
            spd_o       <= SPD_NORMAL;
            bad_o       <= 1'b0;
        end else begin
            if (frise) begin
                mcnt_q <= {{(CNT_W-1){1'b0}}, mrise};
                flen_q <= {{(LEN_W-1){1'b0}}, 1'b1};
            end else begin
                if (mrise && mcnt_q != '1) mcnt_q <= mcnt_q + 1'b1;
                if (flen_q != '1)          flen_q <= flen_q + 1'b1;
            end

            if (!enable) begin
                prev_ok_q <= 1'b0;
                bad_o     <= 1'b0;
            end else if (frise) begin
                prev_ok_q   <= res.ok;
                prev_code_q <= res.code;
                prev_spd_q  <= cls;
                if (res.ok && prev_ok_q && res.code == prev_code_q && cls == prev_spd_q) begin
                    code_o <= res.code;
                    spd_o  <= cls;
                    bad_o  <= 1'b0;
                end else begin
                    bad_o  <= 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/aclk_supervisor.sv
module aclk_supervisor
    import aclk_pkg::*;
#(
    parameter int STOP_CYC       = 200,
    parameter int BCLK_WIN       = 2000,
    parameter int FRAME_WIN      = 32768,
    parameter int MIN_EDGES      = 4,
    parameter int NORM_FRAME_MIN = 3100,
    parameter int FS32_FRAME_MIN = 5400,
    parameter int RATIO_TOL      = 2,
    parameter int CNT_W          = 12
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       mclk,
    input  logic       bclk,
    input  logic       fclk,
    input  logic       chip_en,
    input  logic       auto_sel,
    input  logic       pin_mode,
    input  logic [2:0] speed_field,
    output logic       dp_pwrdn,
    output logic       out_hiz,
    output logic       mclk_lost,
    output logic       auto_active,
    output logic [2:0] speed_class,
    output logic [2:0] ratio_code,
    output logic       ratio_bad
);
    localparam int NCLK  = 3;
    localparam int SW    = $clog2(STOP_CYC + 1);
    localparam int LEN_W = $clog2(FS32_FRAME_MIN) + 2;

    logic [NCLK-1:0] raw_clk;
    logic [NCLK-1:0] rise;
    logic [NCLK-1:0] present;
    logic [SW-1:0]   stop_q;
    logic            lost_q;
    logic            started_q;
    logic            pwrdn_q;
    logic            en_d_q;
    logic            auto_q;
    speed_e          speed_q;
    ratio_e          meter_code;
    speed_e          meter_spd;
    logic            meter_bad;

    assign raw_clk = {fclk, bclk, mclk};

    for (genvar g = 0; g < NCLK; g++) begin : g_clk
        localparam int WIN_G = (g == 0) ? STOP_CYC : ((g == 1) ? BCLK_WIN : FRAME_WIN);
        clk_edge_det u_sync (
            .clk     (clk),
            .rst     (rst),
            .async_i (raw_clk[g]),
            .rise_o  (rise[g])
        );
        clk_presence #(.WIN(WIN_G), .MIN_EDGES(MIN_EDGES)) u_pres (
            .clk       (clk),
            .rst       (rst),
            .rise_i    (rise[g]),
            .present_o (present[g])
        );
    end

    // Master-clock stop timer
    always_ff @(posedge clk) begin
        if (rst || !chip_en) begin
            stop_q <= '0;
            lost_q <= 1'b0;
        end else if (rise[0]) begin
            stop_q <= '0;
            lost_q <= 1'b0;
        end else if (stop_q == SW'(STOP_CYC - 1)) begin
            lost_q <= 1'b1;
        end else begin
            stop_q <= stop_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            started_q <= 1'b0;
            pwrdn_q   <= 1'b1;
            en_d_q    <= 1'b0;
            auto_q    <= 1'b0;
            speed_q   <= SPD_NORMAL;
        end else begin
            if (&present) started_q <= 1'b1;
            pwrdn_q <= !chip_en || !started_q || lost_q;
            en_d_q  <= chip_en;
            auto_q  <= chip_en && en_d_q && auto_sel;
            if (auto_q)        speed_q <= meter_spd;
            else if (pin_mode) speed_q <= SPD_NORMAL;
            else               speed_q <= field_to_speed(speed_field);
        end
    end

    ratio_meter #(
        .CNT_W          (CNT_W),
        .LEN_W          (LEN_W),
        .NORM_FRAME_MIN (NORM_FRAME_MIN),
        .FS32_FRAME_MIN (FS32_FRAME_MIN),
        .RATIO_TOL      (RATIO_TOL)
    ) u_meter (
        .clk    (clk),
        .rst    (rst),
        .enable (auto_q),
        .mrise  (rise[0]),
        .frise  (rise[2]),
        .code_o (meter_code),
        .spd_o  (meter_spd),
        .bad_o  (meter_bad)
    );

    assign dp_pwrdn    = pwrdn_q;
    assign out_hiz     = pwrdn_q;
    assign mclk_lost   = lost_q;
    assign auto_active = auto_q;
    assign speed_class = speed_q;
    assign ratio_code  = meter_code;
    assign ratio_bad   = meter_bad;
endmodule

// File: rtl/aclk_supervisor_chk.sv
module aclk_supervisor_chk (
    input logic       clk,
    input logic       rst,
    input logic       chip_en,
    input logic       pin_mode,
    input logic       dp_pwrdn,
    input logic       mclk_lost,
    input logic       auto_active,
    input logic [2:0] speed_class,
    input logic [2:0] ratio_code,
    input logic       ratio_bad
);
    AST_LOST_PWRDN:   assert property (@(posedge clk) disable iff (rst) mclk_lost |=> dp_pwrdn);                 // R3
    AST_LOST_NEEDS_EN: assert property (@(posedge clk) disable iff (rst) mclk_lost |-> $past(chip_en));          // R3
    AST_DISABLE_PWRDN: assert property (@(posedge clk) disable iff (rst) !chip_en |=> dp_pwrdn);                // R12
    AST_RESUME_MANUAL: assert property (@(posedge clk) disable iff (rst) $rose(chip_en) |=> !auto_active);      // R5
    AST_PIN_NORMAL:   assert property (@(posedge clk) disable iff (rst)
                                       (!auto_active && pin_mode) |=> speed_class == 3'd0);                    // R7
    AST_CODE_HELD:    assert property (@(posedge clk) disable iff (rst) ratio_bad |-> $stable(ratio_code));     // R10
    AST_CODE_LEGAL:   assert property (@(posedge clk) disable iff (rst) ratio_code <= 3'd4);                    // R8
    AST_MANUAL_NO_BAD: assert property (@(posedge clk) disable iff (rst) !auto_active |=> !ratio_bad);          // R13
endmodule

bind aclk_supervisor aclk_supervisor_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .chip_en     (chip_en),
    .pin_mode    (pin_mode),
    .dp_pwrdn    (dp_pwrdn),
    .mclk_lost   (mclk_lost),
    .auto_active (auto_active),
    .speed_class (speed_class),
    .ratio_code  (ratio_code),
    .ratio_bad   (ratio_bad)
);

// File: tb/sim_aclk_supervisor.sv
`timescale 1ns/1ps
module sim_aclk_supervisor;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       mclk = 1'b0, bclk = 1'b0, fclk = 1'b0;
    logic       chip_en = 1'b0, auto_sel = 1'b0, pin_mode = 1'b0;
    logic [2:0] speed_field = 3'd0;
    logic       dp_pwrdn, out_hiz, mclk_lost, auto_active, ratio_bad;
    logic [2:0] speed_class, ratio_code;

    int  checks = 0, fails = 0;
    bit  finished = 0;
    int  mclk_half = 40, bclk_half = 160, fclk_half = 10240;
    bit  mclk_run = 0, bclk_run = 0, fclk_run = 0;

    aclk_supervisor #(.FRAME_WIN(17000)) u0 (
        .clk(clk), .rst(rst), .mclk(mclk), .bclk(bclk), .fclk(fclk),
        .chip_en(chip_en), .auto_sel(auto_sel), .pin_mode(pin_mode),
        .speed_field(speed_field), .dp_pwrdn(dp_pwrdn), .out_hiz(out_hiz),
        .mclk_lost(mclk_lost), .auto_active(auto_active),
        .speed_class(speed_class), .ratio_code(ratio_code), .ratio_bad(ratio_bad)
    );

    always #2.5 clk = ~clk;

    // Audio clocks toggle on whole ns, reference edges fall on half ns
    initial begin #1; forever begin if (mclk_run) begin #(mclk_half); mclk = ~mclk; end else #1; end end
    initial begin #1; forever begin if (bclk_run) begin #(bclk_half); bclk = ~bclk; end else #1; end end
    initial begin #1; forever begin if (fclk_run) begin #(fclk_half); fclk = ~fclk; end else #1; end end

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    task automatic t_reset_state();
        cycles(3);
        rst = 1'b0;
        cycles(2);
        chk("R1", "dp_pwrdn", dp_pwrdn, 1);
        chk("R1", "out_hiz", out_hiz, 1);
        chk("R1", "mclk_lost", mclk_lost, 0);
        chk("R1", "auto_active", auto_active, 0);
        chk("R1", "speed_class", speed_class, 0);
        chk("R1", "ratio_code", ratio_code, 0);
        chk("R1", "ratio_bad", ratio_bad, 0);
    endtask

    task automatic t_startup();
        chip_en = 1'b1; mclk_run = 1; bclk_run = 1;
        cycles(3000);
        chk("R2", "pwrdn without frame clock", dp_pwrdn, 1);
        fclk_run = 1;
        for (int i = 0; i < 40000 && dp_pwrdn; i++) @(negedge clk);
        chk("R2", "pwrdn after all clocks", dp_pwrdn, 0);
        chk("R2", "hiz after all clocks", out_hiz, 0);
    endtask

    task automatic t_manual();
        pin_mode = 1'b0; speed_field = 3'd2; cycles(2);
        chk("R6", "field quad", speed_class, 2);
        speed_field = 3'd4; cycles(2);
        chk("R6", "field hex", speed_class, 4);
        speed_field = 3'd6; cycles(2);
        chk("R6", "reserved field", speed_class, 0);
        pin_mode = 1'b1; speed_field = 3'd3; cycles(2);
        chk("R7", "pin mode forced normal", speed_class, 0);
        chk("R13", "manual ratio_bad", ratio_bad, 0);
        pin_mode = 1'b0;
    endtask

    task automatic t_auto(input string req, input int mh, input int fh,
                          input int exp_bad, input int exp_code, input int exp_spd);
        mclk_half = mh; fclk_half = fh;
        cycles(4 * (2 * fh / 5) + 1000);
        chk(req, "ratio_bad", ratio_bad, exp_bad);
        chk(req, "ratio_code", ratio_code, exp_code);
        chk(req, "speed_class", speed_class, exp_spd);
    endtask

    task automatic t_stop();
        mclk_run = 0;
        cycles(150);
        chk("R3", "lost before timeout", mclk_lost, 0);
        cycles(70);
        chk("R3", "lost after timeout", mclk_lost, 1);
        chk("R3", "pwrdn on loss", dp_pwrdn, 1);
        chk("R3", "hiz on loss", out_hiz, 1);
        mclk_run = 1;
        cycles(30);
        chk("R4", "lost cleared", mclk_lost, 0);
        chk("R4", "pwrdn released", dp_pwrdn, 0);
        chk("R4", "code held", ratio_code, 0);
        chk("R4", "speed held", speed_class, 1);
    endtask

    task automatic t_enable();
        chip_en = 1'b0; cycles(1);
        chk("R12", "pwrdn when disabled", dp_pwrdn, 1);
        chk("R12", "hiz when disabled", out_hiz, 1);
        chk("R5", "auto off when disabled", auto_active, 0);
        cycles(3);
        chip_en = 1'b1; cycles(1);
        chk("R5", "manual right after enable", auto_active, 0);
        cycles(1);
        chk("R5", "auto after settle", auto_active, 1);
        auto_sel = 1'b0; cycles(2);
        chk("R5", "manual selected", auto_active, 0);
    endtask

    initial begin
        t_reset_state();
        t_startup();
        t_manual();
        auto_sel = 1'b1; cycles(2);
        chk("R5", "auto selected", auto_active, 1);
        t_auto("R8", 40, 10240, 0, 0, 0);   // 256, normal
        t_auto("R8", 20, 10240, 0, 2, 0);   // 512, normal
        t_auto("R9", 10, 11520, 1, 2, 0);   // 1152 on short frame: invalid
        t_auto("R9", 15, 17280, 0, 4, 0);   // 1152 on long frame: legal
        t_auto("R10", 80, 10240, 1, 4, 0);  // 128: invalid, code held
        t_auto("R11", 20, 5120, 0, 0, 1);   // 256 at double speed
        t_stop();
        t_enable();
        finish_run();
    end

    initial begin
        repeat (195000) @(posedge clk);
        fails++;
        $display("FAIL watchdog all actual=timeout expected=done");
        finish_run();
    end
endmodule